// File: doc/BRIEF.md
# Thread-Block Grid Dispatcher

The dispatcher hands the blocks of a three-dimensional grid to a small set of processing clusters. A launch loads the grid bounds, an optional block cap, the per-kernel limit on concurrent blocks per cluster and the kernel's threads per block. The dispatcher then keeps the current (x, y, z) block index and a count of blocks still to hand out.

Each `step_i` pulse starts a scan that visits the clusters in ascending order, one cluster per clock. A cluster gets a block when its active-block count plus one fits under the limit and blocks remain. Each grant shows up for one cycle on a registered strobe, together with the cluster id and the block index. A retire pulse from a cluster lowers its active count. `done_o` reports that the grid has been fully handed out and every cluster has drained.

Top module: `grid_dispatcher`

## Requirements
- R1: A launch with `blk_threads_i` <= THREADS_PER_CORE (256) clears `err_o` and resets the index to (0,0,0). It sets the remaining count to `blk_cap_i` when that is nonzero, otherwise to `grid_x_i*grid_y_i*grid_z_i`. An empty grid with no cap issues nothing.
- R2: A launch with `blk_threads_i` > THREADS_PER_CORE sets `err_o` and zeroes the remaining count. No block is issued until a later accepted launch.
- R3: Successive grants carry indices that advance x first. When x+1 reaches the x bound, x returns to 0 and y advances. When y+1 reaches the y bound, y returns to 0 and z advances.
- R4: z advances only while it is below the z bound and never wraps. Once the z bound is reached (possible when the cap exceeds the grid size), grants repeat z = bound while x and y keep walking.
- R5: A cluster is granted a block only if its active count plus one is at most the effective limit. The effective limit is `clu_limit_i` clamped to MAX_ACTIVE (8) and is latched at launch. A limit of 0 blocks every grant.
- R6: A `step_i` pulse seen while idle with blocks remaining starts a scan of clusters 0..N_CLU-1. The outcome for cluster k appears on the outputs after the (k+2)th rising edge, counting the edge that samples `step_i` as the first. A cluster receives at most one block per scan.
- R7: Each grant lowers the remaining count by one. Once the count is zero, no further grant is made, even by a scan already in progress.
- R8: A `retire_i[c]` pulse lowers cluster c's active count by one. A pulse to a cluster whose count is already zero has no effect.
- R9: `done_o` is high exactly when the remaining count is zero and every cluster's active count is zero.
- R10: After reset, `issue_o` and `err_o` are low and `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Load a new kernel's grid and limits |
| grid_x_i | input | DIM_W | Grid bound in x |
| grid_y_i | input | DIM_W | Grid bound in y |
| grid_z_i | input | DIM_W | Grid bound in z |
| blk_cap_i | input | 3*DIM_W | Block cap, 0 = whole grid |
| clu_limit_i | input | ACT_W | Max concurrent blocks per cluster for this kernel |
| blk_threads_i | input | THR_W | Threads per block of the kernel |
| step_i | input | 1 | Start one dispatch scan |
| retire_i | input | N_CLU | Per-cluster block completion pulses |
| issue_o | output | 1 | Grant strobe |
| issue_clu_o | output | CLU_W | Granted cluster |
| issue_x_o | output | DIM_W | Granted block x |
| issue_y_o | output | DIM_W | Granted block y |
| issue_z_o | output | DIM_W | Granted block z |
| err_o | output | 1 | Last launch rejected |
| done_o | output | 1 | Grid handed out and all clusters idle |

## Verification
The bench targets several corner cases and the failure each one would expose:
- Row and plane turnover in the index walk. A wrong carry would repeat or skip an index.
- A cap larger than the grid. A wrapping z would return to zero instead of sticking at its bound.
- A limit above the clamp. Missing clamping would let a cluster exceed eight active blocks.
- A retire to an idle cluster. An underflowing counter would lock that cluster out of later grants.
- An oversized kernel. Treating it as accepted would issue blocks despite `err_o`.
- The count reaching zero in the middle of a scan. A design that kept scanning would over-issue.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/grid_walker.sv
module grid_walker #(
  parameter int DIM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIM_W-1:0] bx_i,
  input  logic [DIM_W-1:0] by_i,
  input  logic [DIM_W-1:0] bz_i,
  input  logic             adv_i,
  output logic [DIM_W-1:0] x_o,
  output logic [DIM_W-1:0] y_o,
  output logic [DIM_W-1:0] z_o,
  output logic [DIM_W-1:0] bnd_x_o
);
  logic [DIM_W-1:0] bx_q, by_q, bz_q, x_q, y_q, z_q;
  logic x_wrap, y_wrap;

  assign x_wrap = ((DIM_W+1)'(x_q) + (DIM_W+1)'(1)) >= (DIM_W+1)'(bx_q);
  assign y_wrap = ((DIM_W+1)'(y_q) + (DIM_W+1)'(1)) >= (DIM_W+1)'(by_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bx_q <= '0; by_q <= '0; bz_q <= '0;
      x_q  <= '0; y_q  <= '0; z_q  <= '0;
    end else if (load_i) begin
      bx_q <= bx_i; by_q <= by_i; bz_q <= bz_i;
      x_q  <= '0;   y_q  <= '0;   z_q  <= '0;
    end else if (adv_i) begin
      if (!x_wrap) begin
        x_q <= x_q + DIM_W'(1);
      end else begin
        x_q <= '0;
        if (!y_wrap) begin
          y_q <= y_q + DIM_W'(1);
        end else begin
          y_q <= '0;
          if (z_q < bz_q) z_q <= z_q + DIM_W'(1); // saturate, no wrap
        end
      end
    end
  end

  assign x_o     = x_q;
  assign y_o     = y_q;
  assign z_o     = z_q;
  assign bnd_x_o = bx_q;
endmodule

// File: rtl/active_tracker.sv
module active_tracker #(
  parameter int N_CLU = 4,
  parameter int ACT_W = 4,
  parameter int CLU_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   inc_i,
  input  logic [CLU_W-1:0]       inc_id_i,
  input  logic [N_CLU-1:0]       retire_i,
  output logic [N_CLU*ACT_W-1:0] act_o,
  output logic                   all_idle_o
);
  for (genvar c = 0; c < N_CLU; c++) begin : g_clu
    logic [ACT_W-1:0] cnt_q;
    logic up, dn;
    assign up = inc_i && (inc_id_i == CLU_W'(c));
    assign dn = retire_i[c] && (cnt_q != '0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_q + ACT_W'(up) - ACT_W'(dn);
    end
    assign act_o[c*ACT_W +: ACT_W] = cnt_q;
  end

  assign all_idle_o = (act_o == '0);
endmodule

// File: rtl/grid_dispatcher.sv
module grid_dispatcher
  import dispatch_pkg::*;
#(
  parameter int N_CLU            = 4,
  parameter int MAX_ACTIVE       = 8,
  parameter int DIM_W            = 16,
  parameter int THR_W            = 11,
  parameter int THREADS_PER_CORE = 256,
  localparam int CLU_W = (N_CLU > 1) ? $clog2(N_CLU) : 1,
  localparam int ACT_W = $clog2(MAX_ACTIVE + 1),
  localparam int REM_W = 3 * DIM_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic [DIM_W-1:0]   grid_x_i,
  input  logic [DIM_W-1:0]   grid_y_i,
  input  logic [DIM_W-1:0]   grid_z_i,
  input  logic [REM_W-1:0]   blk_cap_i,
  input  logic [ACT_W-1:0]   clu_limit_i,
  input  logic [THR_W-1:0]   blk_threads_i,
  input  logic               step_i,
  input  logic [N_CLU-1:0]   retire_i,
  output logic               issue_o,
  output logic [CLU_W-1:0]   issue_clu_o,
  output logic [DIM_W-1:0]   issue_x_o,
  output logic [DIM_W-1:0]   issue_y_o,
  output logic [DIM_W-1:0]   issue_z_o,
  output logic               err_o,
  output logic               done_o
);
  scan_state_e            st_q;
  logic [CLU_W-1:0]       ptr_q;
  logic [REM_W-1:0]       rem_q;
  logic [ACT_W-1:0]       lim_q;
  logic [N_CLU*ACT_W-1:0] act_q;
  logic                   all_idle;
  logic [DIM_W-1:0]       cur_x, cur_y, cur_z, bnd_x;
  logic                   bad_kernel, grant;
  logic [ACT_W-1:0]       lim_eff, ptr_act;
  logic [REM_W-1:0]       grid_size;

  assign bad_kernel = 32'(blk_threads_i) > THREADS_PER_CORE;
  assign lim_eff    = (32'(clu_limit_i) > MAX_ACTIVE) ? ACT_W'(MAX_ACTIVE) : clu_limit_i;
  assign grid_size  = REM_W'(grid_x_i) * REM_W'(grid_y_i) * REM_W'(grid_z_i);
  assign ptr_act    = act_q[ptr_q*ACT_W +: ACT_W];
  assign grant      = !launch_i && (st_q == ST_SCAN) && (rem_q != '0) &&
                      (((ACT_W+1)'(ptr_act) + (ACT_W+1)'(1)) <= (ACT_W+1)'(lim_q));

  grid_walker #(.DIM_W(DIM_W)) u_walker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (launch_i),
    .bx_i    (grid_x_i),
    .by_i    (grid_y_i),
    .bz_i    (grid_z_i),
    .adv_i   (grant),
    .x_o     (cur_x),
    .y_o     (cur_y),
    .z_o     (cur_z),
    .bnd_x_o (bnd_x)
  );

  active_tracker #(.N_CLU(N_CLU), .ACT_W(ACT_W), .CLU_W(CLU_W)) u_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (grant),
    .inc_id_i   (ptr_q),
    .retire_i   (retire_i),
    .act_o      (act_q),
    .all_idle_o (all_idle)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ptr_q       <= '0;
      rem_q       <= '0;
      lim_q       <= '0;
      err_o       <= 1'b0;
      issue_o     <= 1'b0;
      issue_clu_o <= '0;
      issue_x_o   <= '0;
      issue_y_o   <= '0;
      issue_z_o   <= '0;
    end else begin
      issue_o <= 1'b0;
      if (launch_i) begin
        st_q  <= ST_IDLE;
        lim_q <= lim_eff;
        err_o <= bad_kernel;
        if (bad_kernel)              rem_q <= '0;
        else if (blk_cap_i != '0)    rem_q <= blk_cap_i;
        else                         rem_q <= grid_size;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (step_i && rem_q != '0) begin
              st_q  <= ST_SCAN;
              ptr_q <= '0;
            end
          end
          default: begin
            if (grant) begin
              issue_o     <= 1'b1;
              issue_clu_o <= ptr_q;
              issue_x_o   <= cur_x;
              issue_y_o   <= cur_y;
              issue_z_o   <= cur_z;
              rem_q       <= rem_q - REM_W'(1);
            end
            if (ptr_q == CLU_W'(N_CLU - 1) || (grant && rem_q == REM_W'(1)))
              st_q <= ST_IDLE;
            ptr_q <= ptr_q + CLU_W'(1);
          end
        endcase
      end
    end
  end

  assign done_o = (rem_q == '0) && all_idle;
endmodule

// File: rtl/grid_dispatcher_chk.sv
module grid_dispatcher_chk #(
  parameter int N_CLU = 4,
  parameter int ACT_W = 4,
  parameter int CLU_W = 2,
  parameter int DIM_W = 16,
  parameter int REM_W = 48
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   issue_o,
  input logic [CLU_W-1:0]       issue_clu_o,
  input logic [DIM_W-1:0]       issue_x_o,
  input logic                   err_o,
  input logic                   done_o,
  input logic [REM_W-1:0]       rem_q,
  input logic [ACT_W-1:0]       lim_q,
  input logic [N_CLU*ACT_W-1:0] act_q,
  input logic [DIM_W-1:0]       bnd_x
);
  assert_rejected_no_issue_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !issue_o);

  assert_x_in_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && bnd_x != '0) |-> (issue_x_o < bnd_x));

  assert_limit_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (act_q[issue_clu_o*ACT_W +: ACT_W] <= lim_q));

  assert_count_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> ($past(rem_q) == rem_q + REM_W'(1)));

  assert_done_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !issue_o);
endmodule

bind grid_dispatcher grid_dispatcher_chk #(
  .N_CLU(N_CLU), .ACT_W(ACT_W), .CLU_W(CLU_W), .DIM_W(DIM_W), .REM_W(REM_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .issue_o     (issue_o),
  .issue_clu_o (issue_clu_o),
  .issue_x_o   (issue_x_o),
  .err_o       (err_o),
  .done_o      (done_o),
  .rem_q       (rem_q),
  .lim_q       (lim_q),
  .act_q       (act_q),
  .bnd_x       (bnd_x)
);

// File: tb/test_grid_dispatcher.sv
module test_grid_dispatcher;
  localparam int CLK_T = 10;
  localparam int N     = 4;
  localparam int DW    = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic launch = 0, step = 0;
  logic [DW-1:0] gx = 0, gy = 0, gz = 0;
  logic [3*DW-1:0] cap = 0;
  logic [3:0] lim = 0;
  logic [10:0] thr = 0;
  logic [N-1:0] retire = 0;
  logic issue, err, done;
  logic [1:0] iclu;
  logic [DW-1:0] ix, iy, iz;

  int checks = 0, errors = 0;
  bit finished = 0;
  int mx, my, mz, bx, by, bz, mlim;
  longint mrem;
  int mact [N];
  bit merr;

  always #(CLK_T/2) clk = ~clk;

  grid_dispatcher i_grid_dispatcher (
    .clk_i(clk), .rst_ni(rst_n), .launch_i(launch),
    .grid_x_i(gx), .grid_y_i(gy), .grid_z_i(gz), .blk_cap_i(cap),
    .clu_limit_i(lim), .blk_threads_i(thr), .step_i(step), .retire_i(retire),
    .issue_o(issue), .issue_clu_o(iclu), .issue_x_o(ix), .issue_y_o(iy),
    .issue_z_o(iz), .err_o(err), .done_o(done)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic bit exp_done();
    bit idle = 1;
    for (int c = 0; c < N; c++) if (mact[c] != 0) idle = 0;
    return (mrem == 0) && idle;
  endfunction

  function automatic void advance();
    if (mx + 1 < bx) mx++;
    else begin
      mx = 0;
      if (my + 1 < by) my++;
      else begin
        my = 0;
        if (mz < bz) mz++;
      end
    end
  endfunction

  task automatic do_launch(input int x, y, z, input longint c, input int l, t, input string tag);
    @(negedge clk);
    gx = DW'(x); gy = DW'(y); gz = DW'(z); cap = (3*DW)'(c); lim = 4'(l); thr = 11'(t);
    launch = 1;
    @(negedge clk);
    launch = 0;
    bx = x; by = y; bz = z; mx = 0; my = 0; mz = 0;
    mlim = (l > 8) ? 8 : l;
    merr = (t > 256);
    if (merr) mrem = 0;
    else if (c != 0) mrem = c;
    else mrem = longint'(x) * y * z;
    check(err == merr, {tag, " R1/R2 err"}, 64'(err), 64'(merr));
    check(done == exp_done(), {tag, " R9 done"}, 64'(done), 64'(exp_done()));
  endtask

  task automatic do_step(input string tag);
    @(negedge clk); step = 1;
    @(negedge clk); step = 0;
    for (int k = 0; k < N; k++) begin
      bit e_iss = (mrem > 0) && (mact[k] + 1 <= mlim);
      logic [63:0] ev = {13'd0, 1'b1, 2'(k), DW'(mx), DW'(my), DW'(mz)};
      logic [63:0] av;
      if (e_iss) begin
        mact[k]++; mrem--; advance();
      end
      @(negedge clk);
      av = {13'd0, issue, iclu, ix, iy, iz};
      if (e_iss) check(av == ev, {tag, " R6 grant"}, av, ev);
      else       check(issue == 1'b0, {tag, " R5/R7 no grant"}, 64'(issue), 64'd0);
    end
    @(negedge clk);
    check(done == exp_done(), {tag, " R9 done after scan"}, 64'(done), 64'(exp_done()));
  endtask

  task automatic do_retire(input logic [N-1:0] m, input string tag);
    @(negedge clk); retire = m;
    @(negedge clk); retire = 0;
    for (int c = 0; c < N; c++) if (m[c] && mact[c] > 0) mact[c]--;
    check(done == exp_done(), {tag, " R8 done"}, 64'(done), 64'(exp_done()));
  endtask

  initial begin
    #(CLK_T * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < N; c++) mact[c] = 0;
    mrem = 0;
    repeat (3) @(negedge clk);
    check(issue == 0, "R10 issue reset", 64'(issue), 0);
    check(err == 0, "R10 err reset", 64'(err), 0);
    check(done == 1, "R10 done reset", 64'(done), 1);
    rst_n = 1;
    @(negedge clk);

    // R3: 2x2 walk, one per cluster
    do_launch(2, 2, 1, 0, 1, 64, "R3 2x2");
    do_step("R3 walk");
    do_step("R7 exhausted");
    do_retire(4'hF, "R8 drain");
    do_retire(4'hF, "R8 retire at zero");
    do_launch(1, 1, 1, 0, 1, 64, "R8 relaunch");
    do_step("R8 no underflow");
    do_retire(4'hF, "R8 drain2");

    // R4: z saturates when cap exceeds grid
    do_launch(1, 1, 2, 5, 8, 128, "R4 cap");
    do_step("R4 z sat a");
    do_step("R4 z sat b");
    do_retire(4'hF, "R4 drain");
    repeat (8) do_retire(4'hF, "R4 drain more");

    // R2: oversized kernel
    do_launch(2, 2, 2, 0, 4, 300, "R2 reject");
    do_step("R2 no issue");
    do_launch(0, 3, 3, 0, 4, 256, "R1 empty grid");
    do_step("R1 empty no issue");

    // R5: limit clamp
    do_launch(40, 1, 1, 0, 12, 32, "R5 clamp");
    repeat (10) do_step("R5 clamp");
    repeat (8) do_retire(4'hF, "R5 drain");
    do_launch(3, 3, 1, 0, 0, 32, "R5 zero limit");
    do_step("R5 zero limit");

    // random kernels
    for (int k = 0; k < 25; k++) begin
      int rx = $urandom_range(0, 3), ry = $urandom_range(1, 3), rz = $urandom_range(1, 2);
      longint rc = ($urandom_range(0, 2) == 0) ? longint'($urandom_range(1, 30)) : 0;
      do_launch(rx, ry, rz, rc, $urandom_range(0, 12), ($urandom_range(0, 7) == 0) ? 400 : 100, "R1 rand");
      for (int s = 0; s < 6; s++) begin
        do_step("R6 rand");
        do_retire(N'($urandom), "R8 rand");
      end
      repeat (10) do_retire(4'hF, "R9 rand drain");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule